// File: doc/BRIEF.md
# Indirect Register Window Bridge

This block lets a host reach a large per-channel internal register space through four directly addressed window registers. The host loads a channel number and an internal offset, then writes a command into a control/status register. The block either fetches the addressed internal word into its data register or stores the data register contents into the addressed internal word. The block runs the access over a request/acknowledge backend port toward per-channel storage.

While the backend access is pending, the control/status register shows a busy flag. The host polls this flag and waits for it to clear before it reads fetched data or starts another access. A typical read-modify-write loads the channel and offset, issues a fetch, polls busy, reads the data register, edits some bits, writes the data register back and issues a store.

Top module: `regwin_bridge`

## Requirements
- R1: After reset all four window registers read zero, busy is clear and no backend request is raised.
- R2: The window decodes word addresses 0x38 (channel, CHAN_W bits), 0x3A (control/status), 0x3B (offset, OFS_W bits) and 0x3C (data). Channel, offset and data read back what was written, truncated to their width. Any other address reads zero, and a write to it changes nothing.
- R3: A control/status write with bits [1:0] equal to 2'b10 (for example 0x6) starts a fetch. In the next cycle the block raises a request with the write-enable low, carrying the current channel and offset.
- R4: A control/status write with bits [1:0] equal to 2'b01 (for example 0x5) starts a store. The request carries the write-enable high and the data register contents, and the backend word takes that value.
- R5: Bits [3:2] of a control/status write set the mode field, which reads back unchanged. Command bits 2'b00 or 2'b11 start no access, so writing 0x4 only sets mode 1.
- R6: Busy (control/status bit 8) and the backend request rise in the cycle after a command write. They stay high until the cycle after the acknowledge, so an access with backend latency L shows busy for L+1 cycles.
- R7: On a fetch acknowledge, the data register takes the returned word on the same clock edge at which busy falls.
- R8: While busy is set, every host write to the window is ignored, including a write that lands in the acknowledge cycle. Channel, offset, data and mode keep their values, no new access starts, and the backend channel, offset and write data stay stable.
- R9: A control/status read returns busy in bit 8 and the mode in bits [3:2], with all other bits zero (the command bits read zero).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host write strobe for one cycle |
| hostAddr | input | 7 | Host word address into the window |
| hostWrData | input | DATA_W | Host write data |
| hostRdData | output | DATA_W | Window read data for hostAddr (combinational) |
| beReq | output | 1 | Backend request, held until acknowledged |
| beWe | output | 1 | Backend access is a store when high |
| beChan | output | CHAN_W | Backend channel number |
| beOffset | output | OFS_W | Backend internal offset |
| beWrData | output | DATA_W | Backend store data |
| beAck | input | 1 | Backend acknowledge, one cycle |
| beRdData | input | DATA_W | Backend fetch data, valid with beAck |

## Verification
The collision of interest is a host command write that falls on the clock edge where the backend acknowledge closes the previous access. At that edge busy is still set, so the command must be dropped. The bench counts the acknowledge latency and places a store command exactly on that edge. It then confirms that busy stays low, that no request follows, and that the backend word and the data register are unchanged. A second overlap, a fetched word arriving on the edge where busy falls, is judged by reading the data register in the first cycle busy reads clear.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam int HOST_AW = 7;
  localparam logic [HOST_AW-1:0] ADDR_CHAN = 7'h38;
  localparam logic [HOST_AW-1:0] ADDR_CSR  = 7'h3A;
  localparam logic [HOST_AW-1:0] ADDR_OFS  = 7'h3B;
  localparam logic [HOST_AW-1:0] ADDR_DATA = 7'h3C;
  localparam int BUSY_BIT = 8;
  localparam logic [1:0] CMD_FETCH = 2'b10;
  localparam logic [1:0] CMD_STORE = 2'b01;

  typedef struct packed {
    logic ldChan;
    logic ldOfs;
    logic ldData;
    logic capRd;
  } dpCtl_t;
endpackage

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
  import regwin_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWrEn,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [DATA_W-1:0]  hostWrData,
  input  logic               beAck,
  output logic               busy,
  output logic               opWrite,
  output logic [1:0]         mode,
  output dpCtl_t             ctl
);
  logic busyQ;
  logic opWrQ;
  logic [1:0] modeQ;
  logic wrOk;
  logic wrCsr;
  logic startFetch;
  logic startStore;

  assign wrOk       = hostWrEn && !busyQ;
  assign wrCsr      = wrOk && (hostAddr == ADDR_CSR);
  assign startFetch = wrCsr && (hostWrData[1:0] == CMD_FETCH);
  assign startStore = wrCsr && (hostWrData[1:0] == CMD_STORE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      opWrQ <= 1'b0;
      modeQ <= 2'b00;
    end else begin
      if (wrCsr) modeQ <= hostWrData[3:2];
      if (startFetch || startStore) begin
        busyQ <= 1'b1;
        opWrQ <= startStore;
      end else if (busyQ && beAck) begin
        busyQ <= 1'b0;
      end
    end
  end

  always_comb begin
    ctl.ldChan = wrOk && (hostAddr == ADDR_CHAN);
    ctl.ldOfs  = wrOk && (hostAddr == ADDR_OFS);
    ctl.ldData = wrOk && (hostAddr == ADDR_DATA);
    ctl.capRd  = busyQ && beAck && !opWrQ;
  end

  assign busy    = busyQ;
  assign opWrite = opWrQ;
  assign mode    = modeQ;
endmodule

// File: rtl/regwin_dp.sv
module regwin_dp
  import regwin_pkg::*;
#(
  parameter int CHAN_W = 2,
  parameter int OFS_W  = 9,
  parameter int DATA_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtl_t             ctl,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [DATA_W-1:0]  hostWrData,
  input  logic [DATA_W-1:0]  beRdData,
  input  logic               busy,
  input  logic [1:0]         mode,
  output logic [DATA_W-1:0]  hostRdData,
  output logic [CHAN_W-1:0]  beChan,
  output logic [OFS_W-1:0]   beOffset,
  output logic [DATA_W-1:0]  beWrData
);
  logic [CHAN_W-1:0] chanQ;
  logic [OFS_W-1:0]  ofsQ;
  logic [DATA_W-1:0] dataQ;
  logic [DATA_W-1:0] csrView;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanQ <= '0;
      ofsQ  <= '0;
      dataQ <= '0;
    end else begin
      if (ctl.ldChan) chanQ <= hostWrData[CHAN_W-1:0];
      if (ctl.ldOfs)  ofsQ  <= hostWrData[OFS_W-1:0];
      if (ctl.capRd)       dataQ <= beRdData;
      else if (ctl.ldData) dataQ <= hostWrData;
    end
  end

  always_comb begin
    csrView = '0;
    csrView[BUSY_BIT] = busy;
    csrView[3:2] = mode;
    case (hostAddr)
      ADDR_CHAN: hostRdData = DATA_W'(chanQ);
      ADDR_CSR:  hostRdData = csrView;
      ADDR_OFS:  hostRdData = DATA_W'(ofsQ);
      ADDR_DATA: hostRdData = dataQ;
      default:   hostRdData = '0;
    endcase
  end

  assign beChan   = chanQ;
  assign beOffset = ofsQ;
  assign beWrData = dataQ;
endmodule

// File: rtl/regwin_bridge.sv
module regwin_bridge
  import regwin_pkg::*;
#(
  parameter int CHAN_W = 2,
  parameter int OFS_W  = 9,
  parameter int DATA_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWrEn,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [DATA_W-1:0]  hostWrData,
  output logic [DATA_W-1:0]  hostRdData,
  output logic               beReq,
  output logic               beWe,
  output logic [CHAN_W-1:0]  beChan,
  output logic [OFS_W-1:0]   beOffset,
  output logic [DATA_W-1:0]  beWrData,
  input  logic               beAck,
  input  logic [DATA_W-1:0]  beRdData
);
  dpCtl_t ctl;
  logic busy;
  logic opWrite;
  logic [1:0] mode;

  regwin_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .beAck(beAck), .busy(busy), .opWrite(opWrite),
    .mode(mode), .ctl(ctl)
  );

  regwin_dp #(.CHAN_W(CHAN_W), .OFS_W(OFS_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .beRdData(beRdData), .busy(busy), .mode(mode),
    .hostRdData(hostRdData), .beChan(beChan), .beOffset(beOffset),
    .beWrData(beWrData)
  );

  assign beReq = busy;
  assign beWe  = opWrite;
endmodule

// File: rtl/regwin_chk.sv
module regwin_chk
  import regwin_pkg::*;
#(
  parameter int CHAN_W = 2,
  parameter int OFS_W  = 9,
  parameter int DATA_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               hostWrEn,
  input logic [HOST_AW-1:0] hostAddr,
  input logic [DATA_W-1:0]  hostWrData,
  input logic [DATA_W-1:0]  hostRdData,
  input logic               beReq,
  input logic               beWe,
  input logic [CHAN_W-1:0]  beChan,
  input logic [OFS_W-1:0]   beOffset,
  input logic [DATA_W-1:0]  beWrData,
  input logic               beAck,
  input logic [DATA_W-1:0]  beRdData
);
  // R3
  req_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(beReq) |-> $past(hostWrEn && hostAddr == ADDR_CSR &&
      (hostWrData[1:0] == CMD_FETCH || hostWrData[1:0] == CMD_STORE)));

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    beReq && !beAck |=> beReq);

  // R8
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    beReq && beAck |=> !beReq);

  // R8
  be_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    beReq && !beAck |=> $stable(beChan) && $stable(beOffset) &&
      $stable(beWrData) && $stable(beWe));

  // R9
  busy_view_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostAddr == ADDR_CSR |-> hostRdData[BUSY_BIT] == beReq);

  // R7
  fetch_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(beReq && beAck && !beWe) && hostAddr == ADDR_DATA |->
      hostRdData == $past(beRdData));
endmodule

bind regwin_bridge regwin_chk #(.CHAN_W(CHAN_W), .OFS_W(OFS_W), .DATA_W(DATA_W))
  u_chk (.*);

// File: tb/sim_regwin_bridge.sv
module sim_regwin_bridge;
  import regwin_pkg::*;
  localparam int CHAN_W = 2;
  localparam int OFS_W  = 9;
  localparam int DATA_W = 16;
  localparam int NCH = 1 << CHAN_W;
  localparam int NOF = 1 << OFS_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWrEn = 1'b0;
  logic [HOST_AW-1:0] hostAddr = '0;
  logic [DATA_W-1:0] hostWrData = '0;
  logic [DATA_W-1:0] hostRdData;
  logic beReq, beWe;
  logic [CHAN_W-1:0] beChan;
  logic [OFS_W-1:0] beOffset;
  logic [DATA_W-1:0] beWrData;
  logic beAck = 1'b0;
  logic [DATA_W-1:0] beRdData = '0;

  int total = 0;
  int bad = 0;
  int lat = 1;
  int cnt = 0;
  bit doneFlag = 0;
  logic [DATA_W-1:0] mem [NCH][NOF];

  always #2 clk = ~clk;

  regwin_bridge #(.CHAN_W(CHAN_W), .OFS_W(OFS_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .beReq(beReq),
    .beWe(beWe), .beChan(beChan), .beOffset(beOffset), .beWrData(beWrData),
    .beAck(beAck), .beRdData(beRdData)
  );

  // backend storage with latency lat cycles
  always @(posedge clk) begin
    beAck <= 1'b0;
    if (beReq && !beAck) begin
      if (cnt >= lat - 1) begin
        beAck <= 1'b1;
        cnt <= 0;
        if (beWe) mem[beChan][beOffset] <= beWrData;
        else beRdData <= mem[beChan][beOffset];
      end else cnt <= cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [HOST_AW-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic hostRead(input logic [HOST_AW-1:0] a, output logic [DATA_W-1:0] v);
    @(negedge clk);
    hostAddr = a;
    #1 v = hostRdData;
  endtask

  // counts negedges with busy set, starting at the current negedge
  task automatic busyCycles(output int n);
    n = 0;
    while (beReq && n < 50) begin
      n++;
      @(negedge clk);
    end
  endtask

  function automatic logic [OFS_W-1:0] pickOfs(input int i);
    case (i)
      0: return 9'h12D;
      1: return 9'h135;
      2: return 9'h137;
      3: return 9'h15E;
      4: return 9'h164;
      5: return 9'h000;
      6: return 9'h1FF;
      default: return 9'h0A5;
    endcase
  endfunction

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=0 expected=1");
    finishRun();
  end

  initial begin
    logic [DATA_W-1:0] v, oldV, newV, seed;
    int n;
    for (int c = 0; c < NCH; c++)
      for (int o = 0; o < NOF; o++)
        mem[c][o] = DATA_W'((c * 16'h3B1) ^ (o * 16'h0107) ^ 16'h5A00);
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    hostRead(ADDR_CHAN, v); chk(v == 0, "R1 chan", v, 0);
    hostRead(ADDR_CSR, v);  chk(v == 0, "R1 csr", v, 0);
    hostRead(ADDR_OFS, v);  chk(v == 0, "R1 ofs", v, 0);
    hostRead(ADDR_DATA, v); chk(v == 0, "R1 data", v, 0);
    chk(beReq == 0, "R1 req", beReq, 0);

    // R2 window decode and width truncation
    hostWrite(ADDR_CHAN, 16'hFFFF);
    hostWrite(ADDR_OFS, 16'hFFFF);
    hostWrite(ADDR_DATA, 16'hBEEF);
    hostWrite(7'h39, 16'h1234);
    hostWrite(7'h3D, 16'h4321);
    hostRead(ADDR_CHAN, v); chk(v == 16'h3, "R2 chan", v, 3);
    hostRead(ADDR_OFS, v);  chk(v == 16'h1FF, "R2 ofs", v, 16'h1FF);
    hostRead(ADDR_DATA, v); chk(v == 16'hBEEF, "R2 data", v, 16'hBEEF);
    hostRead(7'h39, v);     chk(v == 0, "R2 hole", v, 0);
    hostRead(7'h3D, v);     chk(v == 0, "R2 hole2", v, 0);

    // R5 / R9 mode handling, no-op commands
    hostWrite(ADDR_CSR, 16'h0004);
    repeat (2) @(negedge clk);
    chk(beReq == 0, "R5 mode1 no access", beReq, 0);
    hostRead(ADDR_CSR, v); chk(v == 16'h0004, "R9 csr mode1", v, 4);
    hostWrite(ADDR_CSR, 16'hFE0B);
    repeat (2) @(negedge clk);
    chk(beReq == 0, "R5 cmd3 no access", beReq, 0);
    hostRead(ADDR_CSR, v); chk(v == 16'h0008, "R9 csr mode2", v, 8);
    hostWrite(ADDR_CSR, 16'h0000);
    hostRead(ADDR_CSR, v); chk(v == 0, "R5 mode0", v, 0);

    // sweep: fetch, modify, store, refetch over channels, offsets, latencies
    for (int c = 0; c < NCH; c++) begin
      for (int i = 0; i < 8; i++) begin
        lat = ((c * 8 + i) % 8) + 1;
        hostWrite(ADDR_CHAN, DATA_W'(c));
        hostWrite(ADDR_OFS, DATA_W'(pickOfs(i)));
        hostWrite(ADDR_CSR, 16'h0006);
        // R3 request properties one cycle after the command
        chk(beReq && !beWe, "R3 fetch req", {beReq, beWe}, 2);
        chk(beChan == CHAN_W'(c) && beOffset == pickOfs(i), "R3 fetch addr",
            {beChan, beOffset}, {CHAN_W'(c), pickOfs(i)});
        #1 chk(hostRdData[BUSY_BIT] == 1'b1 || hostAddr != ADDR_CSR, "R9 busy view", hostRdData, 0);
        busyCycles(n);
        chk(n == lat + 1, "R6 busy length", n, lat + 1);
        oldV = mem[c][pickOfs(i)];
        hostRead(ADDR_DATA, v); chk(v == oldV, "R7 fetched", v, oldV);
        hostRead(ADDR_CSR, v); chk(v == 16'h0004, "R9 csr idle", v, 4);
        newV = oldV ^ DATA_W'(16'h0C0F + c * 3 + i);
        hostWrite(ADDR_DATA, newV);
        hostWrite(ADDR_CSR, 16'h0005);
        chk(beReq && beWe && beWrData == newV, "R4 store req", beWrData, newV);
        busyCycles(n);
        chk(n == lat + 1, "R6 store busy length", n, lat + 1);
        chk(mem[c][pickOfs(i)] == newV, "R4 stored", mem[c][pickOfs(i)], newV);
      end
    end

    // R8 host writes during busy are ignored
    lat = 8;
    hostWrite(ADDR_CHAN, 16'h1);
    hostWrite(ADDR_OFS, 16'h164);
    hostWrite(ADDR_CSR, 16'h0006);
    hostWrite(ADDR_CHAN, 16'h2);
    hostWrite(ADDR_OFS, 16'h010);
    hostWrite(ADDR_DATA, 16'h7777);
    hostWrite(ADDR_CSR, 16'h0009);
    busyCycles(n);
    repeat (3) @(negedge clk);
    chk(beReq == 0, "R8 no second access", beReq, 0);
    hostRead(ADDR_CHAN, v); chk(v == 1, "R8 chan kept", v, 1);
    hostRead(ADDR_OFS, v);  chk(v == 16'h164, "R8 ofs kept", v, 16'h164);
    hostRead(ADDR_DATA, v); chk(v == mem[1][9'h164], "R8 data is fetched", v, mem[1][9'h164]);
    hostRead(ADDR_CSR, v);  chk(v == 16'h0004, "R8 mode kept", v, 4);

    // R8 store command landing on the acknowledge edge is dropped
    lat = 3;
    seed = mem[1][9'h164];
    hostWrite(ADDR_DATA, 16'hA5A5);
    hostWrite(ADDR_CSR, 16'h0006);
    repeat (lat - 1) @(negedge clk);
    hostWrEn = 1'b0;
    @(negedge clk);
    chk(beAck == 1'b1, "R8 collision timing", beAck, 1);
    hostWrEn = 1'b1; hostAddr = ADDR_CSR; hostWrData = 16'h0005;
    @(negedge clk);
    hostWrEn = 1'b0;
    repeat (3) begin
      chk(beReq == 0, "R8 collision no access", beReq, 0);
      @(negedge clk);
    end
    chk(mem[1][9'h164] == seed, "R8 word untouched", mem[1][9'h164], seed);
    hostRead(ADDR_DATA, v); chk(v == seed, "R7 data after collision", v, seed);

    finishRun();
  end
endmodule